// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small multicycle processor. It holds a micro-program counter, a microcode ROM and a dispatch ROM. In every cycle it reads one microinstruction from the ROM at the current micro-address. Part of that word selects how the next micro-address is formed. The rest holds grouped, vertically encoded datapath fields, and small decoders expand those fields into the individual strobes, mux selects and write enables of the datapath.

The next micro-address has only three sources: the next sequential word, the word zero that begins the shared fetch routine, or an entry point read from a dispatch ROM indexed by the opcode held in the instruction register. A microinstruction that touches memory repeats as a wait state for as long as memory reports that it is not ready. Both ROMs are constant tables that are built when the block elaborates. The datapath, the memories and the handling of exceptions sit outside the block. An opcode with no routine is sent to a dedicated trap word.

Top module: `microSequencer`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, and on the first cycle after it falls, `uAddr` is 0. A reset in the middle of a routine returns the block to word 0.
- R2: A word whose sequencing code is 00 (next) moves `uAddr` to `uAddr`+1. Word 0 goes to 1 (decode). Words 2, 4, 6 and 9 go to 3, 5, 7 and 10. Word 7 goes to 8.
- R3: Word 1 uses sequencing code 01 (dispatch) and jumps to the entry for the opcode: 0x00→2, 0x0D→4, 0x23→6, 0x2B→9, 0x04→11, 0x02→12.
- R4: Any other opcode makes word 1 dispatch to the trap word 13.
- R5: Sequencing codes 10 (fetch) and 11 (reserved) both load 0. Words 3, 5, 8, 10, 11, 12 and 13 end with fetch.
- R6: Words 0, 7 and 10 access memory. While `memReady` is low on such a word, `uAddr` holds and the same controls repeat.
- R7: Word 0 drives `ctlMemRead`=1, `ctlAddrFromAlu`=0 and `ctlPcSource`=0 (PC+4). `ctlIrWrite` and `ctlPcWrite` are high only in a cycle where `memReady` is high.
- R8: The register-write field decodes as follows. Word 3 gives regWrite with `ctlRegDstRd`=1. Word 5 gives regWrite with rt as the destination and ALU data. Word 8 gives regWrite with rt as the destination and `ctlWbFromMem`=1. All other words have regWrite=0.
- R9: The memory field decodes as follows. Word 7 is a data read with `ctlAddrFromAlu`=1. Word 10 drives `ctlMemWrite`=1 with `ctlAddrFromAlu`=1. Reads and writes are never asserted together.
- R10: The ALU fields use these codes: srcA 0=PC and 1=A; srcB 0=B, 1=sign-extended immediate, 2=zero-extended immediate, 3=shifted sign-extended immediate; op 0=add, 1=sub, 2=or, 3=function field. Word 1 drives operand load with PC + shifted immediate. The words use: 2 A,B,func; 4 A,zx,or; 6 and 9 A,sx,add. Word 11 drives A,B,sub with `ctlPcWriteCond`=1 and `ctlPcSource`=1. Word 12 drives `ctlPcWrite`=1 with `ctlPcSource`=2.
- R11: The trap word 13 drives `ctlTrap`=1, and no other word does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| memReady | input | 1 | Memory finishes the current access this cycle |
| uAddr | output | 4 | Current micro-address |
| ctlIrWrite | output | 1 | Load the instruction register |
| ctlMemRead | output | 1 | Memory read |
| ctlMemWrite | output | 1 | Memory write |
| ctlAddrFromAlu | output | 1 | Memory address comes from the ALU result register (0 selects PC) |
| ctlRegWrite | output | 1 | Register file write enable |
| ctlRegDstRd | output | 1 | Write destination is rd (0 selects rt) |
| ctlWbFromMem | output | 1 | Write data comes from the memory data register |
| ctlAluSrcA | output | 1 | ALU A operand select |
| ctlAluSrcB | output | 2 | ALU B operand select |
| ctlAluOp | output | 2 | ALU operation |
| ctlPcWrite | output | 1 | Unconditional PC write |
| ctlPcWriteCond | output | 1 | PC write when the operands are equal |
| ctlPcSource | output | 2 | PC source: 0 PC+4, 1 branch target, 2 jump |
| ctlOperandLoad | output | 1 | Latch operands A, B and the branch target |
| ctlTrap | output | 1 | Undefined-opcode trap |

## Verification
The assertions inside the RTL check the sequencing rules on every cycle. They check that a sequential step adds one, that a fetch lands on zero, that a dispatch lands only on a legal entry point, and that a held word keeps its address. They also check that the instruction-register and PC strobes stay low during a wait, and that a read and a write never appear together. Only the bench scenarios can show that each opcode reaches the right routine and that the whole control word is correct in each step. Those scenarios also cover long memory waits and a reset that lands in the middle of a routine.

// File: rtl/mseqPkg.sv
package mseqPkg;

  typedef enum logic [1:0] {
    SEQ_NEXT     = 2'b00,
    SEQ_DISPATCH = 2'b01,
    SEQ_FETCH    = 2'b10,
    SEQ_RSVD     = 2'b11
  } seqMode_e;

  typedef enum logic [1:0] {
    MEM_NONE   = 2'd0,
    MEM_IFETCH = 2'd1,
    MEM_DREAD  = 2'd2,
    MEM_DWRITE = 2'd3
  } memOp_e;

  typedef enum logic [1:0] {
    RW_NONE   = 2'd0,
    RW_RD_ALU = 2'd1,
    RW_RT_ALU = 2'd2,
    RW_RT_MEM = 2'd3
  } regWr_e;

  typedef enum logic [1:0] {
    PC_KEEP   = 2'd0,
    PC_INC    = 2'd1,
    PC_BRANCH = 2'd2,
    PC_JUMP   = 2'd3
  } pcOp_e;

  typedef struct packed {
    seqMode_e    seq;
    logic        srcA;
    logic [1:0]  srcB;
    logic [1:0]  aluOp;
    memOp_e      mem;
    regWr_e      regWr;
    pcOp_e       pc;
    logic        opLoad;
    logic        trap;
  } microWord_t;

  typedef struct packed {
    seqMode_e mode;
    logic     hold;
  } seqStrobe_t;

  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_RTYPE  = 2;
  localparam int UA_ORI    = 4;
  localparam int UA_LOAD   = 6;
  localparam int UA_STORE  = 9;
  localparam int UA_BEQ    = 11;
  localparam int UA_JUMP   = 12;
  localparam int UA_TRAP   = 13;

  function automatic int dispatchTarget(input int opc);
    case (opc)
      'h00:    return UA_RTYPE;
      'h0D:    return UA_ORI;
      'h23:    return UA_LOAD;
      'h2B:    return UA_STORE;
      'h04:    return UA_BEQ;
      'h02:    return UA_JUMP;
      default: return UA_TRAP;
    endcase
  endfunction

  // ALU codes: srcA 0 PC / 1 A; srcB 0 B, 1 sx, 2 zx, 3 sx<<2; op 0 add, 1 sub, 2 or, 3 func
  function automatic microWord_t ucodeWord(input int addr);
    microWord_t w;
    w = '0;
    w.seq = SEQ_FETCH;
    case (addr)
      0:  begin w.mem = MEM_IFETCH; w.pc = PC_INC; w.seq = SEQ_NEXT; end
      1:  begin w.srcB = 2'd3; w.opLoad = 1'b1; w.seq = SEQ_DISPATCH; end
      2:  begin w.srcA = 1'b1; w.aluOp = 2'd3; w.seq = SEQ_NEXT; end
      3:  begin w.regWr = RW_RD_ALU; end
      4:  begin w.srcA = 1'b1; w.srcB = 2'd2; w.aluOp = 2'd2; w.seq = SEQ_NEXT; end
      5:  begin w.regWr = RW_RT_ALU; end
      6:  begin w.srcA = 1'b1; w.srcB = 2'd1; w.seq = SEQ_NEXT; end
      7:  begin w.mem = MEM_DREAD; w.seq = SEQ_NEXT; end
      8:  begin w.regWr = RW_RT_MEM; end
      9:  begin w.srcA = 1'b1; w.srcB = 2'd1; w.seq = SEQ_NEXT; end
      10: begin w.mem = MEM_DWRITE; end
      11: begin w.srcA = 1'b1; w.aluOp = 2'd1; w.pc = PC_BRANCH; end
      12: begin w.pc = PC_JUMP; end
      13: begin w.trap = 1'b1; end
      default: begin w.seq = SEQ_RSVD; end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/uSeqPath.sv
module uSeqPath
  import mseqPkg::*;
#(
  parameter int OPC_W   = 6,
  parameter int UADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  seqStrobe_t         strb,
  output logic [UADDR_W-1:0] uAddr
);
  localparam int DISP_DEPTH = 1 << OPC_W;

  logic [UADDR_W-1:0] dispRom [DISP_DEPTH];
  logic [UADDR_W-1:0] upc, upcNext, upcInc;

  for (genvar i = 0; i < DISP_DEPTH; i++) begin : gDisp
    assign dispRom[i] = UADDR_W'(dispatchTarget(i));
  end

  assign upcInc = upc + 1'b1;

  always_comb begin
    case (strb.mode)
      SEQ_NEXT:     upcNext = upcInc;
      SEQ_DISPATCH: upcNext = dispRom[opcode];
      default:      upcNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             upc <= '0;
    else if (!strb.hold) upc <= upcNext;
  end

  assign uAddr = upc;

  p_next_step_r2: assert property (@(posedge clk) disable iff (rst)
    (strb.mode == SEQ_NEXT && !strb.hold) |=> upc == UADDR_W'($past(upc) + 1'b1));

  p_dispatch_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (strb.mode == SEQ_DISPATCH && !strb.hold) |=>
      (upc == UADDR_W'(UA_RTYPE) || upc == UADDR_W'(UA_ORI) || upc == UADDR_W'(UA_LOAD) ||
       upc == UADDR_W'(UA_STORE) || upc == UADDR_W'(UA_BEQ) || upc == UADDR_W'(UA_JUMP) ||
       upc == UADDR_W'(UA_TRAP)));

  p_fetch_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ((strb.mode == SEQ_FETCH || strb.mode == SEQ_RSVD) && !strb.hold) |=> upc == '0);

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
    strb.hold |=> $stable(upc));

endmodule

// File: rtl/uSeqCtrl.sv
module uSeqCtrl
  import mseqPkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [UADDR_W-1:0] uAddr,
  input  logic               memReady,
  output seqStrobe_t         strb,
  output logic               irWrite,
  output logic               memRead,
  output logic               memWrite,
  output logic               addrFromAlu,
  output logic               regWrite,
  output logic               regDstRd,
  output logic               wbFromMem,
  output logic               aluSrcA,
  output logic [1:0]         aluSrcB,
  output logic [1:0]         aluOp,
  output logic               pcWrite,
  output logic               pcWriteCond,
  output logic [1:0]         pcSource,
  output logic               operandLoad,
  output logic               trap
);
  localparam int UDEPTH = 1 << UADDR_W;

  microWord_t ucodeRom [UDEPTH];
  microWord_t uw;
  logic       memAccess, stall;

  for (genvar i = 0; i < UDEPTH; i++) begin : gRom
    assign ucodeRom[i] = ucodeWord(i);
  end

  assign uw        = ucodeRom[uAddr];
  assign memAccess = (uw.mem != MEM_NONE);
  assign stall     = memAccess && !memReady;

  assign strb.mode = uw.seq;
  assign strb.hold = stall;

  // memory field decoder
  always_comb begin
    memRead     = 1'b0;
    memWrite    = 1'b0;
    addrFromAlu = 1'b0;
    irWrite     = 1'b0;
    case (uw.mem)
      MEM_IFETCH: begin memRead = 1'b1; irWrite = !stall; end
      MEM_DREAD:  begin memRead = 1'b1; addrFromAlu = 1'b1; end
      MEM_DWRITE: begin memWrite = 1'b1; addrFromAlu = 1'b1; end
      default: ;
    endcase
  end

  // register-write field decoder
  always_comb begin
    regWrite  = (uw.regWr != RW_NONE);
    regDstRd  = (uw.regWr == RW_RD_ALU);
    wbFromMem = (uw.regWr == RW_RT_MEM);
  end

  // PC field decoder
  always_comb begin
    pcWrite     = 1'b0;
    pcWriteCond = 1'b0;
    pcSource    = 2'd0;
    case (uw.pc)
      PC_INC:    pcWrite = !stall;
      PC_BRANCH: begin pcWriteCond = 1'b1; pcSource = 2'd1; end
      PC_JUMP:   begin pcWrite = !stall; pcSource = 2'd2; end
      default: ;
    endcase
  end

  assign aluSrcA     = uw.srcA;
  assign aluSrcB     = uw.srcB;
  assign aluOp       = uw.aluOp;
  assign operandLoad = uw.opLoad;
  assign trap        = uw.trap;

  p_wait_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (memRead && !memReady) |-> (!irWrite && !pcWrite));

  p_dest_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(regDstRd && wbFromMem));

  p_mem_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  p_trap_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    trap |-> (!regWrite && !memRead && !memWrite && !pcWrite && strb.mode == SEQ_FETCH));

endmodule

// File: rtl/microSequencer.sv
module microSequencer
  import mseqPkg::*;
#(
  parameter int OPC_W   = 6,
  parameter int UADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               memReady,
  output logic [UADDR_W-1:0] uAddr,
  output logic               ctlIrWrite,
  output logic               ctlMemRead,
  output logic               ctlMemWrite,
  output logic               ctlAddrFromAlu,
  output logic               ctlRegWrite,
  output logic               ctlRegDstRd,
  output logic               ctlWbFromMem,
  output logic               ctlAluSrcA,
  output logic [1:0]         ctlAluSrcB,
  output logic [1:0]         ctlAluOp,
  output logic               ctlPcWrite,
  output logic               ctlPcWriteCond,
  output logic [1:0]         ctlPcSource,
  output logic               ctlOperandLoad,
  output logic               ctlTrap
);
  seqStrobe_t strb;

  uSeqCtrl #(.UADDR_W(UADDR_W)) uCtrl (
    .clk(clk), .rst(rst), .uAddr(uAddr), .memReady(memReady), .strb(strb),
    .irWrite(ctlIrWrite), .memRead(ctlMemRead), .memWrite(ctlMemWrite),
    .addrFromAlu(ctlAddrFromAlu), .regWrite(ctlRegWrite), .regDstRd(ctlRegDstRd),
    .wbFromMem(ctlWbFromMem), .aluSrcA(ctlAluSrcA), .aluSrcB(ctlAluSrcB),
    .aluOp(ctlAluOp), .pcWrite(ctlPcWrite), .pcWriteCond(ctlPcWriteCond),
    .pcSource(ctlPcSource), .operandLoad(ctlOperandLoad), .trap(ctlTrap)
  );

  uSeqPath #(.OPC_W(OPC_W), .UADDR_W(UADDR_W)) uPath (
    .clk(clk), .rst(rst), .opcode(opcode), .strb(strb), .uAddr(uAddr)
  );

  p_reset_zero_r1: assert property (@(posedge clk) $past(rst) |-> uAddr == '0);

endmodule

// File: tb/tb_microSequencer.sv
module tb_microSequencer;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic       memReady;
  logic [3:0] uAddr;
  logic       ctlIrWrite, ctlMemRead, ctlMemWrite, ctlAddrFromAlu, ctlRegWrite;
  logic       ctlRegDstRd, ctlWbFromMem, ctlAluSrcA, ctlPcWrite, ctlPcWriteCond;
  logic       ctlOperandLoad, ctlTrap;
  logic [1:0] ctlAluSrcB, ctlAluOp, ctlPcSource;

  int errors = 0;
  int checks = 0;
  int expUpc = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  microSequencer dut (
    .clk(clk), .rst(rst), .opcode(opcode), .memReady(memReady), .uAddr(uAddr),
    .ctlIrWrite(ctlIrWrite), .ctlMemRead(ctlMemRead), .ctlMemWrite(ctlMemWrite),
    .ctlAddrFromAlu(ctlAddrFromAlu), .ctlRegWrite(ctlRegWrite), .ctlRegDstRd(ctlRegDstRd),
    .ctlWbFromMem(ctlWbFromMem), .ctlAluSrcA(ctlAluSrcA), .ctlAluSrcB(ctlAluSrcB),
    .ctlAluOp(ctlAluOp), .ctlPcWrite(ctlPcWrite), .ctlPcWriteCond(ctlPcWriteCond),
    .ctlPcSource(ctlPcSource), .ctlOperandLoad(ctlOperandLoad), .ctlTrap(ctlTrap)
  );

  wire [17:0] ctlVec = {ctlIrWrite, ctlMemRead, ctlMemWrite, ctlAddrFromAlu, ctlRegWrite,
                        ctlRegDstRd, ctlWbFromMem, ctlAluSrcA, ctlAluSrcB, ctlAluOp,
                        ctlPcWrite, ctlPcWriteCond, ctlPcSource, ctlOperandLoad, ctlTrap};

  function automatic int dispOf(input int opc);
    case (opc)
      'h00: return 2;  'h0D: return 4;  'h23: return 6;
      'h2B: return 9;  'h04: return 11; 'h02: return 12;
      default: return 13;
    endcase
  endfunction

  function automatic bit isMemWord(input int u);
    return (u == 0 || u == 7 || u == 10);
  endfunction

  function automatic int expNext(input int u, input int opc, input bit rdy);
    if (isMemWord(u) && !rdy) return u;
    case (u)
      0: return 1;
      1: return dispOf(opc);
      2, 4, 6, 7, 9: return u + 1;
      default: return 0;
    endcase
  endfunction

  // {ir, mrd, mwr, addrAlu, rw, dstRd, wbMem, srcA, srcB[2], op[2], pcw, pcwc, pcsrc[2], opl, trap}
  function automatic logic [17:0] expCtl(input int u, input bit rdy);
    logic [17:0] c = '0;
    case (u)
      0:  begin c[17] = rdy; c[16] = 1'b1; c[5] = rdy; end
      1:  begin c[9:8] = 2'd3; c[1] = 1'b1; end
      2:  begin c[10] = 1'b1; c[7:6] = 2'd3; end
      3:  begin c[13] = 1'b1; c[12] = 1'b1; end
      4:  begin c[10] = 1'b1; c[9:8] = 2'd2; c[7:6] = 2'd2; end
      5:  begin c[13] = 1'b1; end
      6, 9: begin c[10] = 1'b1; c[9:8] = 2'd1; end
      7:  begin c[16] = 1'b1; c[14] = 1'b1; end
      8:  begin c[13] = 1'b1; c[11] = 1'b1; end
      10: begin c[15] = 1'b1; c[14] = 1'b1; end
      11: begin c[10] = 1'b1; c[7:6] = 2'd1; c[4] = 1'b1; c[3:2] = 2'd1; end
      12: begin c[5] = 1'b1; c[3:2] = 2'd2; end
      13: begin c[0] = 1'b1; end
      default: ;
    endcase
    return c;
  endfunction

  function automatic string ctlTag(input int u);
    case (u)
      0: return "R7";
      3, 5, 8: return "R8";
      7, 10: return "R9";
      13: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  string addrTag = "R1";

  // at a negedge: drive inputs, settle, check, advance model
  task automatic step(input int opc, input bit rdy);
    int nxt;
    opcode = 6'(opc);
    memReady = rdy;
    #1;
    check(uAddr == 4'(expUpc), addrTag, 32'(uAddr), 32'(expUpc));
    check(ctlVec == expCtl(expUpc, rdy), ctlTag(expUpc), 32'(ctlVec), 32'(expCtl(expUpc, rdy)));
    nxt = expNext(expUpc, opc, rdy);
    if (nxt == expUpc && isMemWord(expUpc)) addrTag = "R6";
    else if (expUpc == 1) addrTag = (dispOf(opc) == 13) ? "R4" : "R3";
    else if (nxt == 0) addrTag = "R5";
    else addrTag = "R2";
    expUpc = nxt;
    @(negedge clk);
  endtask

  task automatic runInstr(input int opc, input int waits);
    for (int k = 0; k < waits; k++) step(opc, 1'b0);  // R6 fetch wait
    step(opc, 1'b1);
    step(opc, 1'b1);
    while (expUpc != 0) begin
      if (isMemWord(expUpc)) for (int k = 0; k < waits; k++) step(opc, 1'b0);
      step(opc, 1'b1);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(uAddr == 4'd0, "R1", 32'(uAddr), 0);
    @(negedge clk);
    rst = 1'b0;
    expUpc = 0;
    addrTag = "R1";
  endtask

  initial begin
    int opList[6] = '{'h00, 'h0D, 'h23, 'h2B, 'h04, 'h02};
    void'($urandom(32'd2024));
    rst = 1'b1;
    opcode = '0;
    memReady = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(uAddr == 4'd0, "R1", 32'(uAddr), 0);
    rst = 1'b0;

    // directed: each routine, with and without memory waits
    foreach (opList[i]) runInstr(opList[i], 0);
    foreach (opList[i]) runInstr(opList[i], 3);
    runInstr('h3F, 0);  // R4 undefined opcode
    runInstr('h01, 2);  // R4
    runInstr('h2C, 0);  // R4

    // reset mid-routine (R1)
    step('h23, 1'b1);
    step('h23, 1'b1);
    step('h23, 1'b1);
    step('h23, 1'b0);
    doReset();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int opc;
      bit rdy;
      opc = (($urandom % 4) == 0) ? int'($urandom % 64) : opList[$urandom % 6];
      rdy = (($urandom % 4) != 0);
      step(opc, rdy);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule